// File: doc/BRIEF.md
# Byte-Lane Register Slave with Captured Byte Enables

This block is a small 32-bit register file behind a simple memory-mapped slave port. It accepts word, half-word and byte reads and writes, including accesses whose byte address is not a multiple of four. The position of the bytes inside the 32-bit word is given by the byte-enable mask, and every byte keeps its natural lane on both the write and the read data buses.

Some upstream bridges present the correct byte-enable mask for only the first cycle of a transfer and then let it drift. For that reason the slave stores the mask in the cycle a transfer begins. It uses only that stored copy for write masking and read-lane selection, for as long as it holds the master in wait. Every access lasts a fixed number of wait states, so the stored copy is always needed.

Top module: `be_latch_regslave`

## Requirements
- R1: After a synchronous active-high reset every register reads as zero, and `waitrequest` is low while neither `read` nor `write` is asserted.
- R2: Every access holds `waitrequest` high for exactly two cycles. These are the cycle in which `read` or `write` is first seen while idle and the cycle after it. `waitrequest` is low in the third cycle, which completes the access.
- R3: The byte-enable mask is sampled in the first cycle of an access. Values on the live `byteenable` input in later cycles of the same access have no effect on what is written or read.
- R4: A write with an accepted mask updates only the bytes whose stored enable bit is 1 (bit k selects bits 8k+7:8k). All other bytes of that register keep their old values.
- R5: During the completing cycle of a read, `readdata` carries the addressed register with byte k in bits 8k+7:8k. Lanes whose stored enable bit is 0 read as zero.
- R6: A half-word read at byte offset 2 uses mask 4'b1100 and returns the upper half of the register in bits 31:16, not zeros.
- R7: The register is selected by `address[ADDR_W-1:2]`. The two low address bits have no effect.
- R8: Only the masks 0001, 0010, 0100, 1000, 0011, 1100 and 1111 are accepted. With any other mask a write changes no register, and a read returns zero.
- R9: `readdata` is zero in every cycle that does not complete a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| address | input | ADDR_W | Byte address; bits [ADDR_W-1:2] pick the register |
| read | input | 1 | Read request, held until `waitrequest` is low |
| write | input | 1 | Write request, held until `waitrequest` is low |
| writedata | input | 32 | Write data, bytes in natural lanes |
| byteenable | input | 4 | Live byte-enable mask, reliable in the first cycle only |
| readdata | output | 32 | Read data, valid in the completing cycle |
| waitrequest | output | 1 | High while the slave stalls the master |

## Verification
The case that is hardest to reach from the ports is a mask that is correct in the first cycle and then changes while the slave still holds `waitrequest` high. A well-behaved master never produces it. The stimulus task therefore takes two masks. It drives the first with the request, switches `byteenable` to the second on the next falling edge, and keeps it there until completion. The expected data follows only the first mask, so any use of the live input shows up as extra or missing bytes.

// File: rtl/be_latch_regslave.sv
module be_latch_regslave #(
  parameter int ADDR_W      = 6,
  parameter int WAIT_STATES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] address,
  input  logic              read,
  input  logic              write,
  input  logic [31:0]       writedata,
  input  logic [3:0]        byteenable,
  output logic [31:0]       readdata,
  output logic              waitrequest
);
  localparam int WORDS = 1 << (ADDR_W - 2);
  localparam int CNT_W = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;

  logic [31:0]       regs [WORDS];
  logic [3:0]        be_q;
  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-3:0] widx;
  logic              req, last, mask_ok;
  logic [31:0]       lane_m;

  assign req   = read | write;
  assign widx  = address[ADDR_W-1:2];
  assign last  = busy && (cnt == '0);
  assign waitrequest = req && !last;

  always_comb begin
    case (be_q)
      4'b0001, 4'b0010, 4'b0100, 4'b1000,
      4'b0011, 4'b1100, 4'b1111: mask_ok = 1'b1;
      default:                   mask_ok = 1'b0;
    endcase
  end

  always_comb
    for (int i = 0; i < 4; i++) lane_m[8*i +: 8] = {8{be_q[i]}};

  assign readdata = (last && read && mask_ok) ? (regs[widx] & lane_m) : 32'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      be_q <= '0;
    end else if (!busy) begin
      if (req) begin
        busy <= 1'b1;
        be_q <= byteenable;
        cnt  <= CNT_W'(WAIT_STATES - 1);
      end
    end else if (last) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WORDS; w++) regs[w] <= '0;
    end else if (last && write && mask_ok) begin
      for (int i = 0; i < 4; i++)
        if (be_q[i]) regs[widx][8*i +: 8] <= writedata[8*i +: 8];
    end
  end

  // R2
  wait_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !busy) |-> waitrequest);

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> $stable(be_q));

  // R8
  bad_mask_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (last && write && !mask_ok) |=> regs[$past(widx)] == $past(regs[widx]));

  // R5
  dead_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (last && read) |-> ((readdata & ~lane_m) == 32'd0));

  // R9
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(last && read) |-> (readdata == 32'd0));
endmodule

// File: tb/be_latch_regslave_bench.sv
module be_latch_regslave_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  address;
  logic        read, write;
  logic [31:0] writedata;
  logic [3:0]  byteenable;
  logic [31:0] readdata;
  logic        waitrequest;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  be_latch_regslave u_be_latch_regslave (
    .clk(clk), .rst(rst), .address(address), .read(read), .write(write),
    .writedata(writedata), .byteenable(byteenable),
    .readdata(readdata), .waitrequest(waitrequest)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One access; be1 in first cycle, be2 afterwards. Checks R2 timing.
  task automatic access(input logic wr, input logic [5:0] a, input logic [3:0] be1,
                        input logic [3:0] be2, input logic [31:0] wd,
                        output logic [31:0] rd);
    int stalls = 0;
    @(negedge clk);
    address = a; writedata = wd; byteenable = be1;
    read = !wr; write = wr;
    #1;
    while (waitrequest && stalls < 20) begin
      @(negedge clk);
      byteenable = be2;
      stalls++;
      #1;
    end
    check("R2 wait states", stalls, 2);
    rd = readdata;
    @(negedge clk);
    read = 0; write = 0; byteenable = 0;
  endtask

  function automatic logic [31:0] lanes(input logic [3:0] be);
    for (int i = 0; i < 4; i++) lanes[8*i +: 8] = {8{be[i]}};
  endfunction

  logic [31:0] rd;

  task automatic t_reset;
    @(negedge clk); #1;
    check("R1 idle waitrequest", waitrequest, 0);
    check("R9 idle readdata", readdata, 0);
    access(0, 6'h08, 4'hF, 4'hF, 0, rd);
    check("R1 reset value", rd, 0);
  endtask

  task automatic t_word;
    access(1, 6'h00, 4'hF, 4'hF, 32'hA1B2C3D4, rd);
    access(0, 6'h00, 4'hF, 4'hF, 0, rd);
    check("R5 full word", rd, 32'hA1B2C3D4);
  endtask

  task automatic t_bytes;
    access(1, 6'h04, 4'hF, 4'hF, 32'h11223344, rd);
    access(1, 6'h05, 4'b0010, 4'b0010, 32'h0000EE00, rd);
    access(1, 6'h07, 4'b1000, 4'b1000, 32'h99000000, rd);
    access(0, 6'h04, 4'hF, 4'hF, 0, rd);
    check("R4 byte merge", rd, 32'h9922EE44);
    access(0, 6'h06, 4'b0100, 4'b0100, 0, rd);
    check("R5 byte lane 2", rd, 32'h00220000);
  endtask

  task automatic t_half;
    access(1, 6'h0A, 4'b1100, 4'b1100, 32'hBEEF0000, rd);
    access(1, 6'h08, 4'b0011, 4'b0011, 32'h0000CAFE, rd);
    access(0, 6'h0A, 4'b1100, 4'b1100, 0, rd);
    check("R6 upper half", rd, 32'hBEEF0000);
    access(0, 6'h08, 4'b0011, 4'b0011, 0, rd);
    check("R5 lower half", rd, 32'h0000CAFE);
  endtask

  task automatic t_drift;
    access(1, 6'h10, 4'hF, 4'hF, 32'h01020304, rd);
    access(1, 6'h10, 4'b0001, 4'b1111, 32'hFFFFFF77, rd);
    access(0, 6'h10, 4'hF, 4'hF, 0, rd);
    check("R3 write uses first mask", rd, 32'h01020377);
    access(0, 6'h12, 4'b1100, 4'b0000, 0, rd);
    check("R3 read uses first mask", rd, 32'h01020000);
  endtask

  task automatic t_badmask;
    access(1, 6'h14, 4'hF, 4'hF, 32'h55667788, rd);
    access(1, 6'h14, 4'b0101, 4'b0101, 32'h00000000, rd);
    access(0, 6'h14, 4'hF, 4'hF, 0, rd);
    check("R8 bad mask write ignored", rd, 32'h55667788);
    access(0, 6'h14, 4'b0110, 4'b0110, 0, rd);
    check("R8 bad mask read zero", rd, 0);
  endtask

  task automatic t_lowbits;
    access(1, 6'h1B, 4'hF, 4'hF, 32'hDEADBEEF, rd);
    access(0, 6'h18, 4'hF, 4'hF, 0, rd);
    check("R7 low bits ignored", rd, 32'hDEADBEEF);
    access(0, 6'h1C, 4'hF, 4'hF, 0, rd);
    check("R7 neighbour untouched", rd, 0);
    @(negedge clk); #1;
    check("R9 readdata after read", readdata, 0);
    check("R5 lanes helper", lanes(4'b1100), 32'hFFFF0000);
  endtask

  initial begin
    rst = 1; read = 0; write = 0; address = 0; writedata = 0; byteenable = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_word();
    t_bytes();
    t_half();
    t_drift();
    t_badmask();
    t_lowbits();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule